// File: doc/BRIEF.md
# Colour Subcarrier Phase Generator

This block produces the running phase of the chroma subcarrier for a composite video encoder. A 32-bit accumulator adds a programmable increment on every system clock. The top bits of the accumulator, shifted by an 8-bit hue offset, index an external sine/cosine table. The block counts fields. When the colour field sequence closes (after four fields in the 4-field mode, eight in the 8-field mode), it clears the accumulator so that the subcarrier keeps a fixed relation to vertical sync. A control bit can suppress this clear.

Increment, hue offset and the burst window take effect only on a line-start pulse, so values written in mid-line cannot cause a phase step inside a line. A horizontal counter that restarts on each line-start pulse drives a burst-gate window with programmable start and length. A chroma-off control forces the phase output, the burst gate and the chroma-enable flag low one cycle later. The accumulator keeps running while chroma is off.

Top module: `chroma_phase_gen`

## Requirements
- R1: While `rst` is high at a rising edge, the accumulator, field index, horizontal counter and active configuration clear to zero, and the chroma-enable state goes to 0. The following cycle shows `phase_out`=0, `field_idx`=0, `burst_gate`=0 and `chroma_en`=0.
- R2: With no sequence clear at an edge, the accumulator becomes its previous value plus the active increment, modulo 2^32.
- R3: Each `field_start` pulse advances `field_idx` by one. The last index is 3 when `pal_mode`=0 and 7 when `pal_mode`=1. A pulse at or above the last index returns `field_idx` to 0, which marks the first field.
- R4: A `field_start` pulse that returns `field_idx` to 0 clears the accumulator to 0 when `seq_reset_dis`=0.
- R5: When `seq_reset_dis`=1, that same pulse leaves the accumulator adding its increment as in R2.
- R6: `phase_out` equals accumulator bits [31:22] plus `{hue_offset_active, 2'b00}`, modulo 2^10. The hue offset lines up with the top 8 bits and never changes the accumulator.
- R7: `phase_inc`, `hue_ofs`, `burst_start` and `burst_len` are adopted only at an edge where `line_start`=1. Changes at other times have no effect on the outputs.
- R8: The horizontal counter is 0 after a `line_start` edge. It then rises by one per clock and saturates at 1023. `burst_gate` is high while start <= counter < start+length, with the sum taken in 11 bits.
- R9: An edge with `chroma_off`=1 makes `phase_out`=0, `burst_gate`=0 and `chroma_en`=0 for the next cycle. The accumulator is not stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| line_start | input | 1 | Pulse at horizontal sync start; restarts the line counter and loads the configuration |
| field_start | input | 1 | Pulse at the leading edge of vertical sync |
| pal_mode | input | 1 | 0: 4-field sequence, 1: 8-field sequence |
| seq_reset_dis | input | 1 | 1 suppresses the accumulator clear at sequence wrap |
| chroma_off | input | 1 | 1 kills the subcarrier phase and the burst |
| phase_inc | input | 32 | Phase increment per clock |
| hue_ofs | input | 8 | Hue phase offset |
| burst_start | input | 10 | Burst window start, in clocks from line start |
| burst_len | input | 10 | Burst window length in clocks |
| phase_out | output | 10 | Table address phase |
| field_idx | output | 4 | Position in the colour field sequence, 0 = first |
| burst_gate | output | 1 | Burst window active |
| chroma_en | output | 1 | Chroma enabled |

## Verification
Every output comes from state registered at one rising edge. The effect of inputs present at edge k is therefore visible from just after edge k until edge k+1, with no further pipeline delay. The bench drives inputs on the falling edge and updates its reference state at the rising edge. It compares every output 2 ns after that edge. This holds the expected one-cycle latency for phase, field index, burst gate and chroma enable alike. Line-boundary adoption (R7) adds no latency of its own: the configuration loaded at edge k already governs the outputs that follow edge k.

// File: rtl/csc_pkg.sv
package csc_pkg;

    localparam int ACC_W  = 32;
    localparam int HUE_W  = 8;
    localparam int FCNT_W = 4;
    localparam int HCNT_W = 10;

    typedef enum logic {
        SEQ_FOUR  = 1'b0,
        SEQ_EIGHT = 1'b1
    } seq_len_e;

    typedef struct packed {
        logic [ACC_W-1:0]  inc;
        logic [HUE_W-1:0]  hue;
        logic [HCNT_W-1:0] bst_start;
        logic [HCNT_W-1:0] bst_len;
    } line_cfg_t;

    function automatic logic [FCNT_W-1:0] last_field(seq_len_e m);
        return (m == SEQ_EIGHT) ? FCNT_W'(7) : FCNT_W'(3);
    endfunction

endpackage

// File: rtl/csc_line_ctrl.sv
module csc_line_ctrl
    import csc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              line_start,
    input  line_cfg_t         cfg_in,
    output line_cfg_t         cfg_act,
    output logic [HCNT_W-1:0] hcnt
);

    localparam logic [HCNT_W-1:0] HCNT_MAX = '1;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_act <= '0;
            hcnt    <= '0;
        end else if (line_start) begin
            cfg_act <= cfg_in;
            hcnt    <= '0;
        end else if (hcnt != HCNT_MAX) begin
            hcnt    <= hcnt + 1'b1;
        end
    end

endmodule

// File: rtl/csc_field_seq.sv
module csc_field_seq
    import csc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              field_start,
    input  seq_len_e          mode,
    output logic [FCNT_W-1:0] fidx,
    output logic              seq_wrap
);

    assign seq_wrap = field_start && (fidx >= last_field(mode));

    always_ff @(posedge clk) begin
        if (rst) begin
            fidx <= '0;
        end else if (field_start) begin
            fidx <= seq_wrap ? '0 : fidx + 1'b1;
        end
    end

endmodule

// File: rtl/csc_phase_acc.sv
module csc_phase_acc
    import csc_pkg::*;
#(
    parameter int OUT_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic [ACC_W-1:0] inc,
    input  logic [HUE_W-1:0] hue,
    input  logic             en,
    output logic [ACC_W-1:0] acc_q,
    output logic [OUT_W-1:0] phase
);

    localparam int HUE_SH = OUT_W - HUE_W;

    logic [OUT_W-1:0] top_bits;
    logic [OUT_W-1:0] hue_al;

    generate
        if (HUE_SH >= 0) begin : g_hue_shift
            assign hue_al = OUT_W'(hue) << HUE_SH;
        end else begin : g_hue_trim
            assign hue_al = hue[HUE_W-1 -: OUT_W];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            acc_q <= '0;
        end else begin
            acc_q <= acc_q + inc;
        end
    end

    assign top_bits = acc_q[ACC_W-1 -: OUT_W];
    assign phase    = en ? (top_bits + hue_al) : '0;

endmodule

// File: rtl/chroma_phase_gen.sv
module chroma_phase_gen
    import csc_pkg::*;
#(
    parameter int OUT_W = 10
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               line_start,
    input  logic               field_start,
    input  logic               pal_mode,
    input  logic               seq_reset_dis,
    input  logic               chroma_off,
    input  logic [ACC_W-1:0]   phase_inc,
    input  logic [HUE_W-1:0]   hue_ofs,
    input  logic [HCNT_W-1:0]  burst_start,
    input  logic [HCNT_W-1:0]  burst_len,
    output logic [OUT_W-1:0]   phase_out,
    output logic [FCNT_W-1:0]  field_idx,
    output logic               burst_gate,
    output logic               chroma_en
);

    line_cfg_t         cfg_in;
    line_cfg_t         cfg_act;
    logic [HCNT_W-1:0] hcnt;
    logic              seq_wrap;
    logic              en_q;
    logic [ACC_W-1:0]  acc_q;
    logic [HCNT_W:0]   bst_end;

    assign cfg_in = '{inc: phase_inc, hue: hue_ofs,
                      bst_start: burst_start, bst_len: burst_len};

    csc_line_ctrl u_line (
        .clk        (clk),
        .rst        (rst),
        .line_start (line_start),
        .cfg_in     (cfg_in),
        .cfg_act    (cfg_act),
        .hcnt       (hcnt)
    );

    csc_field_seq u_field (
        .clk         (clk),
        .rst         (rst),
        .field_start (field_start),
        .mode        (seq_len_e'(pal_mode)),
        .fidx        (field_idx),
        .seq_wrap    (seq_wrap)
    );

    csc_phase_acc #(.OUT_W(OUT_W)) u_acc (
        .clk   (clk),
        .rst   (rst),
        .clear (seq_wrap && !seq_reset_dis),
        .inc   (cfg_act.inc),
        .hue   (cfg_act.hue),
        .en    (en_q),
        .acc_q (acc_q),
        .phase (phase_out)
    );

    always_ff @(posedge clk) begin
        if (rst) en_q <= 1'b0;
        else     en_q <= !chroma_off;
    end

    assign bst_end    = {1'b0, cfg_act.bst_start} + {1'b0, cfg_act.bst_len};
    assign burst_gate = en_q && (hcnt >= cfg_act.bst_start)
                             && ({1'b0, hcnt} < bst_end);
    assign chroma_en  = en_q;

endmodule

// File: rtl/chroma_phase_gen_chk.sv
module chroma_phase_gen_chk (
    input logic        clk,
    input logic        rst,
    input logic        line_start,
    input logic        field_start,
    input logic        chroma_off,
    input logic [9:0]  burst_start,
    input logic [9:0]  burst_len,
    input logic [9:0]  phase_out,
    input logic [3:0]  field_idx,
    input logic        burst_gate,
    input logic        chroma_en,
    input logic [31:0] acc_q,
    input logic [31:0] inc_act
);

    // R3
    field_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !field_start |=> $stable(field_idx));

    // R3
    field_step_chk: assert property (@(posedge clk) disable iff (rst)
        (field_start && field_idx < 4'd3) |=> field_idx == $past(field_idx) + 4'd1);

    // R2
    acc_step_chk: assert property (@(posedge clk) disable iff (rst)
        !field_start |=> acc_q == 32'($past(acc_q) + $past(inc_act)));

    // R9
    chroma_kill_chk: assert property (@(posedge clk) disable iff (rst)
        chroma_off |=> (!chroma_en && phase_out == 10'd0 && !burst_gate));

    // R8
    burst_open_chk: assert property (@(posedge clk) disable iff (rst)
        (line_start && !chroma_off && burst_start == 10'd0 && burst_len != 10'd0)
        |=> burst_gate);

    // R8
    burst_closed_chk: assert property (@(posedge clk) disable iff (rst)
        (line_start && burst_start != 10'd0) |=> !burst_gate);

endmodule

bind chroma_phase_gen chroma_phase_gen_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .line_start  (line_start),
    .field_start (field_start),
    .chroma_off  (chroma_off),
    .burst_start (burst_start),
    .burst_len   (burst_len),
    .phase_out   (phase_out),
    .field_idx   (field_idx),
    .burst_gate  (burst_gate),
    .chroma_en   (chroma_en),
    .acc_q       (acc_q),
    .inc_act     (cfg_act.inc)
);

// File: tb/test_chroma_phase_gen.sv
module test_chroma_phase_gen;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        line_start = 1'b0;
    logic        field_start = 1'b0;
    logic        pal_mode = 1'b0;
    logic        seq_reset_dis = 1'b0;
    logic        chroma_off = 1'b0;
    logic [31:0] phase_inc = '0;
    logic [7:0]  hue_ofs = '0;
    logic [9:0]  burst_start = '0;
    logic [9:0]  burst_len = '0;
    logic [9:0]  phase_out;
    logic [3:0]  field_idx;
    logic        burst_gate;
    logic        chroma_en;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // reference state
    logic [31:0] m_acc = '0;
    logic [3:0]  m_f = '0;
    logic [31:0] m_inc = '0;
    logic [7:0]  m_hue = '0;
    logic [9:0]  m_bs = '0;
    logic [9:0]  m_bl = '0;
    logic [9:0]  m_h = '0;
    logic        m_en = 1'b0;

    always #4 clk = ~clk;

    chroma_phase_gen i_chroma_phase_gen (
        .clk(clk), .rst(rst), .line_start(line_start), .field_start(field_start),
        .pal_mode(pal_mode), .seq_reset_dis(seq_reset_dis), .chroma_off(chroma_off),
        .phase_inc(phase_inc), .hue_ofs(hue_ofs), .burst_start(burst_start),
        .burst_len(burst_len), .phase_out(phase_out), .field_idx(field_idx),
        .burst_gate(burst_gate), .chroma_en(chroma_en)
    );

    function automatic logic [9:0] exp_phase();
        return m_en ? 10'(m_acc[31:22] + {m_hue, 2'b00}) : 10'd0;
    endfunction

    function automatic logic exp_gate();
        logic [10:0] e;
        e = {1'b0, m_bs} + {1'b0, m_bl};
        return m_en && (m_h >= m_bs) && ({1'b0, m_h} < e);
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic string event_tag();
        logic [3:0] last;
        last = pal_mode ? 4'd7 : 4'd3;
        if (rst) return "R1";
        if (field_start && m_f >= last) return seq_reset_dis ? "R5" : "R4";
        if (chroma_off) return "R9";
        if (line_start) return "R7";
        return "R2 R6";
    endfunction

    // entered at a falling edge; returns at the next falling edge
    task automatic step(string ptag);
        logic [3:0] last;
        logic       wrap;
        @(posedge clk);
        if (rst) begin
            m_acc = '0; m_f = '0; m_inc = '0; m_hue = '0;
            m_bs = '0; m_bl = '0; m_h = '0; m_en = 1'b0;
        end else begin
            last  = pal_mode ? 4'd7 : 4'd3;
            wrap  = field_start && (m_f >= last);
            m_acc = (wrap && !seq_reset_dis) ? 32'd0 : m_acc + m_inc;
            if (field_start) m_f = wrap ? 4'd0 : m_f + 4'd1;
            if (line_start) begin
                m_inc = phase_inc; m_hue = hue_ofs;
                m_bs = burst_start; m_bl = burst_len; m_h = '0;
            end else if (m_h != 10'h3FF) begin
                m_h = m_h + 10'd1;
            end
            m_en = !chroma_off;
        end
        #2;
        check(ptag, 32'(phase_out), 32'(exp_phase()));
        check("R3", 32'(field_idx), 32'(m_f));
        check("R8", 32'(burst_gate), 32'(exp_gate()));
        check(rst ? "R1" : "R9", 32'(chroma_en), 32'(m_en));
        @(negedge clk);
        line_start = 1'b0;
        field_start = 1'b0;
    endtask

    initial begin
        #(8 * 190000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1F2E3D4C));
        @(negedge clk);
        // R1: reset state
        rst = 1'b1; phase_inc = 32'hDEAD_BEEF; hue_ofs = 8'h55;
        for (int i = 0; i < 3; i++) step("R1");
        rst = 1'b0;

        // R2 R6: load increment and hue on a line boundary
        phase_inc = 32'h0123_4567; hue_ofs = 8'h40; burst_start = 10'd4; burst_len = 10'd6;
        line_start = 1'b1; step("R7");
        for (int i = 0; i < 12; i++) step("R2 R6");

        // R7: mid-line change is ignored until the next line start
        phase_inc = 32'h4000_0000; hue_ofs = 8'hC0; burst_start = 10'd0;
        for (int i = 0; i < 10; i++) step("R7");
        line_start = 1'b1; step("R7");
        for (int i = 0; i < 5; i++) step("R7");

        // R3 R4: four-field sequence with clear
        pal_mode = 1'b0; seq_reset_dis = 1'b0;
        for (int f = 0; f < 6; f++) begin
            field_start = 1'b1; step(f % 4 == 3 ? "R4" : "R3");
            for (int i = 0; i < 3; i++) step("R2");
        end

        // R5: eight-field sequence, clear suppressed
        pal_mode = 1'b1; seq_reset_dis = 1'b1;
        for (int f = 0; f < 10; f++) begin
            field_start = 1'b1; step("R5");
            step("R5");
        end
        seq_reset_dis = 1'b0;
        for (int f = 0; f < 9; f++) begin
            field_start = 1'b1; step("R4");
        end

        // R9: chroma off keeps the accumulator running
        chroma_off = 1'b1;
        for (int i = 0; i < 6; i++) step("R9");
        chroma_off = 1'b0;
        for (int i = 0; i < 4; i++) step("R9");

        // R8: counter saturation with a window near the top
        burst_start = 10'd1020; burst_len = 10'd10;
        line_start = 1'b1; step("R8");
        for (int i = 0; i < 1100; i++) step("R8");

        // constrained random
        for (int n = 0; n < 4000; n++) begin
            line_start  = ($urandom_range(15) == 0);
            field_start = ($urandom_range(31) == 0);
            chroma_off  = ($urandom_range(9) == 0);
            if ($urandom_range(200) == 0) pal_mode = ~pal_mode;
            if ($urandom_range(100) == 0) seq_reset_dis = ~seq_reset_dis;
            if ($urandom_range(3) == 0) begin
                phase_inc   = $urandom();
                hue_ofs     = 8'($urandom());
                burst_start = 10'($urandom_range(20));
                burst_len   = 10'($urandom_range(15));
            end
            step(event_tag());
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule